// File: doc/BRIEF.md
# Four-Step Chained Multiply-Accumulate Sequencer

This controller drives one packed multiply-accumulate instruction that runs four dependent accumulate steps. It takes the decoded fields of the instruction: a 5-bit source register index, a negate flag, a 16-bit lane mask with a flag that turns masking off, a zeroing flag, a broadcast bit and a 2-bit addressing mode. It rejects illegal encodings. It decides whether the 128-bit memory operand has to be loaded. It then hands four operations, one at a time, to an external arithmetic lane array over a valid/ready port.

Each operation names one register of an aligned group of four and one 32-bit element of the memory operand. It also carries the product sign and per-lane write and zero enables. The lane array rounds after every step and returns one result per step, with exception flags and an unmasked-exception indication. The sequencer waits for that result before it issues the next step, because each step accumulates onto the one before it. A fault in a step ends the instruction at that step. Completion is signalled by a one-cycle done pulse. Together with done comes exactly one outcome: commit, which tells the lane array to write the destination and clear everything above the 512-bit vector length; fault; or undefined.

Top module: `fma4_seq`

## Requirements
- R1: A start with `bcast`=1 or `amode`=2'b11 is undefined. One cycle after start, `done` and `ud` are high. No fetch and no operation is issued, and `flags` reads 0.
- R2: A legal start raises `fetch_req` only when `nomask`=1 or `wmask` is nonzero. `fetch_req` then stays high until `fetch_ack`. With no fetch, every operation carries element value 0.
- R3: Operations are issued in step order 0,1,2,3. Step j has `op_step`=j and `op_reg` equal to `src_idx` with its two low bits replaced by j.
- R4: Step j carries `op_elem` = bits [32j+31:32j] of the fetched 128-bit `fetch_data`.
- R5: `op_neg` equals the `negate` value latched at start, for every step.
- R6: Lane i has `op_we[i]`=1 when `nomask`=1 or `wmask[i]`=1. Otherwise `op_zero[i]` equals `zeroing`. A lane never has both bits set.
- R7: After an operation is accepted, `op_valid` stays low until that step's result (`res_valid`) has arrived.
- R8: While `op_valid`=1 and `op_ready`=0, `op_valid` and all operation fields hold their values.
- R9: A result with `res_exc`=1 ends the instruction. The next cycle `done` and `fault` pulse, `commit` stays low, and `fault_step` gives that step's index. No later step is issued.
- R10: `flags` is cleared at a legal start. It becomes the OR of `res_flags` over all results returned so far, including the faulting step's result. Flag bits are {precision, underflow, overflow, denormal, invalid}, with invalid in bit 0.
- R11: One cycle after the fourth result arrives without an exception, `done` and `commit` pulse for exactly one cycle. A start while `busy`=1 has no effect on the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| src_idx | input | 5 | Encoded source register index |
| negate | input | 1 | Subtract the product instead of adding it |
| wmask | input | 16 | Per-lane write mask |
| nomask | input | 1 | Masking disabled, all lanes written |
| zeroing | input | 1 | Masked-off lanes are zeroed |
| bcast | input | 1 | Broadcast bit of the encoding |
| amode | input | 2 | Addressing mode field |
| busy | output | 1 | Instruction in progress |
| fetch_req | output | 1 | Request for the 128-bit memory operand |
| fetch_ack | input | 1 | Memory operand is valid on fetch_data |
| fetch_data | input | 128 | Memory operand, four 32-bit elements |
| op_valid | output | 1 | Operation offered to the lane array |
| op_ready | input | 1 | Lane array accepts the operation |
| op_reg | output | 5 | Register-file read index for this step |
| op_step | output | 2 | Step index |
| op_elem | output | 32 | Selected memory element |
| op_neg | output | 1 | Product sign (1 = subtract) |
| op_we | output | 16 | Per-lane write enables |
| op_zero | output | 16 | Per-lane zero enables |
| res_valid | input | 1 | Step result returned |
| res_flags | input | 5 | Exception flags of the returned step |
| res_exc | input | 1 | Returned step raised an unmasked exception |
| done | output | 1 | One-cycle completion pulse |
| commit | output | 1 | Destination commit (with upper-bit clear), with done |
| fault | output | 1 | Ended by a step exception, with done |
| ud | output | 1 | Rejected as undefined, with done |
| fault_step | output | 2 | Index of the faulting step |
| flags | output | 5 | Accumulated exception flags |

## Verification
Two events can coincide. A second start can arrive while an operation is stalled on `op_ready`. An exception can also come back on the fourth step, in the very cycle that would otherwise lead to the normal commit. The bench injects start pulses in the middle of stalled handshakes and places faults at every step, including the last, with random delays around them. It judges the result by the step sequence, the single outcome bit that goes with `done`, and the reported step index and flags, all checked against a model of the requirements.

// File: rtl/fma4_pkg.sv
package fma4_pkg;
   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_FETCH = 2'd1,
      S_ISSUE = 2'd2,
      S_WAIT  = 2'd3
   } seq_state_t;

   localparam int FLAG_INVALID   = 0;
   localparam int FLAG_DENORMAL  = 1;
   localparam int FLAG_OVERFLOW  = 2;
   localparam int FLAG_UNDERFLOW = 3;
   localparam int FLAG_PRECISION = 4;
   localparam int FLAG_COUNT     = 5;
endpackage

// File: rtl/fma4_decode.sv
module fma4_decode #(
   parameter int LANES  = 16,
   parameter int MODE_W = 2
) (
   input  logic              bcast,
   input  logic [MODE_W-1:0] amode,
   input  logic [LANES-1:0]  wmask,
   input  logic              nomask,
   input  logic              zeroing,
   output logic              illegal,
   output logic              need_fetch,
   output logic [LANES-1:0]  lane_we,
   output logic [LANES-1:0]  lane_zero
);
   localparam logic [MODE_W-1:0] REG_FORM = '1;

   if (LANES < 1) begin : g_bad_lanes
      $error("fma4_decode: LANES must be at least 1");
   end

   assign illegal    = bcast | (amode == REG_FORM);
   assign need_fetch = nomask | (|wmask);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g]   = nomask | wmask[g];
      assign lane_zero[g] = ~lane_we[g] & zeroing;
   end
endmodule

// File: rtl/fma4_elem_pick.sv
module fma4_elem_pick #(
   parameter int ELEM_W = 32,
   parameter int STEPS  = 4,
   localparam int STEP_W = $clog2(STEPS),
   localparam int MEM_W  = ELEM_W * STEPS
) (
   input  logic [MEM_W-1:0]  mem,
   input  logic [STEP_W-1:0] sel,
   output logic [ELEM_W-1:0] elem
);
   logic [ELEM_W-1:0] slice [STEPS];

   for (genvar g = 0; g < STEPS; g++) begin : g_slice
      assign slice[g] = mem[g*ELEM_W +: ELEM_W];
   end

   assign elem = slice[sel];
endmodule

// File: rtl/fma4_flag_acc.sv
module fma4_flag_acc #(
   parameter int FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flags_out <= '0;
      else if (clr)
         flags_out <= '0;
      else if (en)
         flags_out <= flags_out | flags_in;
   end
endmodule

// File: rtl/fma4_seq.sv
module fma4_seq
   import fma4_pkg::*;
#(
   parameter int LANES     = 16,
   parameter int ELEM_W    = 32,
   parameter int STEPS     = 4,
   parameter int REG_IDX_W = 5,
   parameter int MODE_W    = 2,
   parameter int FLAG_W    = FLAG_COUNT,
   localparam int STEP_W   = $clog2(STEPS),
   localparam int MEM_W    = ELEM_W * STEPS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [REG_IDX_W-1:0] src_idx,
   input  logic                 negate,
   input  logic [LANES-1:0]     wmask,
   input  logic                 nomask,
   input  logic                 zeroing,
   input  logic                 bcast,
   input  logic [MODE_W-1:0]    amode,
   output logic                 busy,
   output logic                 fetch_req,
   input  logic                 fetch_ack,
   input  logic [MEM_W-1:0]     fetch_data,
   output logic                 op_valid,
   input  logic                 op_ready,
   output logic [REG_IDX_W-1:0] op_reg,
   output logic [STEP_W-1:0]    op_step,
   output logic [ELEM_W-1:0]    op_elem,
   output logic                 op_neg,
   output logic [LANES-1:0]     op_we,
   output logic [LANES-1:0]     op_zero,
   input  logic                 res_valid,
   input  logic [FLAG_W-1:0]    res_flags,
   input  logic                 res_exc,
   output logic                 done,
   output logic                 commit,
   output logic                 fault,
   output logic                 ud,
   output logic [STEP_W-1:0]    fault_step,
   output logic [FLAG_W-1:0]    flags
);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

   if (STEPS < 2 || (1 << STEP_W) != STEPS) begin : g_bad_steps
      $error("fma4_seq: STEPS must be a power of two of at least 2");
   end
   if (REG_IDX_W <= STEP_W) begin : g_bad_idx
      $error("fma4_seq: REG_IDX_W must exceed the step index width");
   end
   if (FLAG_W != FLAG_COUNT) begin : g_bad_flags
      $error("fma4_seq: FLAG_W must match the flag set");
   end

   seq_state_t st;
   logic [STEP_W-1:0]              step_q;
   logic [REG_IDX_W-STEP_W-1:0]    grp_q;
   logic                           neg_q;
   logic [LANES-1:0]               we_q;
   logic [LANES-1:0]               zero_q;
   logic [MEM_W-1:0]               mem_q;
   logic                           done_q, commit_q, fault_q, ud_q;
   logic [STEP_W-1:0]              fstep_q;

   logic             dec_illegal;
   logic             dec_fetch;
   logic [LANES-1:0] dec_we;
   logic [LANES-1:0] dec_zero;
   logic             accept_start;
   logic             res_take;

   fma4_decode #(
      .LANES (LANES),
      .MODE_W(MODE_W)
   ) u_decode (
      .bcast     (bcast),
      .amode     (amode),
      .wmask     (wmask),
      .nomask    (nomask),
      .zeroing   (zeroing),
      .illegal   (dec_illegal),
      .need_fetch(dec_fetch),
      .lane_we   (dec_we),
      .lane_zero (dec_zero)
   );

   fma4_elem_pick #(
      .ELEM_W(ELEM_W),
      .STEPS (STEPS)
   ) u_pick (
      .mem (mem_q),
      .sel (step_q),
      .elem(op_elem)
   );

   assign accept_start = (st == S_IDLE) && start;
   assign res_take     = (st == S_WAIT) && res_valid;

   fma4_flag_acc #(
      .FLAG_W(FLAG_W)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept_start),
      .en       (res_take),
      .flags_in (res_flags),
      .flags_out(flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         step_q   <= '0;
         grp_q    <= '0;
         neg_q    <= 1'b0;
         we_q     <= '0;
         zero_q   <= '0;
         mem_q    <= '0;
         done_q   <= 1'b0;
         commit_q <= 1'b0;
         fault_q  <= 1'b0;
         ud_q     <= 1'b0;
         fstep_q  <= '0;
      end else begin
         done_q   <= 1'b0;
         commit_q <= 1'b0;
         fault_q  <= 1'b0;
         ud_q     <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  step_q <= '0;
                  if (dec_illegal) begin
                     done_q <= 1'b1;
                     ud_q   <= 1'b1;
                  end else begin
                     grp_q  <= src_idx[REG_IDX_W-1:STEP_W];
                     neg_q  <= negate;
                     we_q   <= dec_we;
                     zero_q <= dec_zero;
                     mem_q  <= '0;
                     st     <= dec_fetch ? S_FETCH : S_ISSUE;
                  end
               end
            end
            S_FETCH: begin
               if (fetch_ack) begin
                  mem_q <= fetch_data;
                  st    <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               if (op_ready)
                  st <= S_WAIT;
            end
            S_WAIT: begin
               if (res_valid) begin
                  if (res_exc) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     fstep_q <= step_q;
                     st      <= S_IDLE;
                  end else if (step_q == LAST_STEP) begin
                     done_q   <= 1'b1;
                     commit_q <= 1'b1;
                     st       <= S_IDLE;
                  end else begin
                     step_q <= step_q + 1'b1;
                     st     <= S_ISSUE;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy       = (st != S_IDLE);
   assign fetch_req  = (st == S_FETCH);
   assign op_valid   = (st == S_ISSUE);
   assign op_reg     = {grp_q, step_q};
   assign op_step    = step_q;
   assign op_neg     = neg_q;
   assign op_we      = we_q;
   assign op_zero    = zero_q;
   assign done       = done_q;
   assign commit     = commit_q;
   assign fault      = fault_q;
   assign ud         = ud_q;
   assign fault_step = fstep_q;
endmodule

// File: rtl/fma4_seq_chk.sv
module fma4_seq_chk #(
   parameter int LANES     = 16,
   parameter int ELEM_W    = 32,
   parameter int STEPS     = 4,
   parameter int REG_IDX_W = 5,
   localparam int STEP_W   = $clog2(STEPS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic                 op_ready,
   input logic [REG_IDX_W-1:0] op_reg,
   input logic [STEP_W-1:0]    op_step,
   input logic [ELEM_W-1:0]    op_elem,
   input logic                 op_neg,
   input logic [LANES-1:0]     op_we,
   input logic [LANES-1:0]     op_zero,
   input logic                 fetch_req,
   input logic                 fetch_ack,
   input logic                 res_valid,
   input logic                 done,
   input logic                 commit,
   input logic                 fault,
   input logic                 ud
);
   AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready |=> op_valid && $stable(op_reg) && $stable(op_step)
         && $stable(op_elem) && $stable(op_neg) && $stable(op_we) && $stable(op_zero)); // R8
   AST_WAIT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ready |=> !op_valid); // R7
   AST_LANE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (op_we & op_zero) == '0); // R6
   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ack |=> fetch_req); // R2
   AST_FETCH_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !op_valid); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({commit, fault, ud}) == 1); // R9
   AST_OUTCOME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit || fault || ud) |-> done); // R11
endmodule

bind fma4_seq fma4_seq_chk #(
   .LANES    (LANES),
   .ELEM_W   (ELEM_W),
   .STEPS    (STEPS),
   .REG_IDX_W(REG_IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_ready (op_ready),
   .op_reg   (op_reg),
   .op_step  (op_step),
   .op_elem  (op_elem),
   .op_neg   (op_neg),
   .op_we    (op_we),
   .op_zero  (op_zero),
   .fetch_req(fetch_req),
   .fetch_ack(fetch_ack),
   .res_valid(res_valid),
   .done     (done),
   .commit   (commit),
   .fault    (fault),
   .ud       (ud)
);

// File: tb/fma4_seq_test.sv
module fma4_seq_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [4:0]   src_idx;
   logic         negate;
   logic [15:0]  wmask;
   logic         nomask, zeroing, bcast;
   logic [1:0]   amode;
   logic         busy, fetch_req, fetch_ack;
   logic [127:0] fetch_data;
   logic         op_valid, op_ready;
   logic [4:0]   op_reg;
   logic [1:0]   op_step;
   logic [31:0]  op_elem;
   logic         op_neg;
   logic [15:0]  op_we, op_zero;
   logic         res_valid;
   logic [4:0]   res_flags;
   logic         res_exc;
   logic         done, commit, fault, ud;
   logic [1:0]   fault_step;
   logic [4:0]   flags;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   fma4_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_idx(src_idx), .negate(negate),
      .wmask(wmask), .nomask(nomask), .zeroing(zeroing), .bcast(bcast), .amode(amode),
      .busy(busy), .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
      .op_valid(op_valid), .op_ready(op_ready), .op_reg(op_reg), .op_step(op_step),
      .op_elem(op_elem), .op_neg(op_neg), .op_we(op_we), .op_zero(op_zero),
      .res_valid(res_valid), .res_flags(res_flags), .res_exc(res_exc),
      .done(done), .commit(commit), .fault(fault), .ud(ud),
      .fault_step(fault_step), .flags(flags)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_we(input logic [15:0] m, input logic nm);
      return nm ? 16'hffff : m;
   endfunction

   function automatic logic [15:0] exp_zero(input logic [15:0] m, input logic nm, input logic z);
      return z ? ~exp_we(m, nm) : 16'h0000;
   endfunction

   // Runs one instruction. fault_at = 4 means no exception.
   task automatic run_instr(input logic [4:0] s, input logic ng, input logic [15:0] m,
                            input logic nm, input logic z, input logic b, input logic [1:0] am,
                            input int fault_at, input int max_dly);
      logic [127:0] data;
      logic         fetched;
      logic [4:0]   fl_acc;
      logic [4:0]   fl;
      logic [31:0]  e_elem;
      data = {$urandom, $urandom, $urandom, $urandom};
      fl_acc = 5'd0;
      @(negedge clk);
      src_idx = s; negate = ng; wmask = m; nomask = nm; zeroing = z; bcast = b; amode = am;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (b || am == 2'b11) begin
         chk(done && ud && !commit && !fault, "R1", "undefined outcome",
             {done, ud, commit, fault}, 4'b1100);
         chk(!fetch_req && !op_valid && !busy, "R1", "no fetch/op", {fetch_req, op_valid, busy}, 3'b000);
         chk(flags == 5'd0, "R1", "flags", flags, 5'd0);
         @(negedge clk);
         chk(!done, "R11", "done pulse width", done, 1'b0);
         return;
      end
      fetched = nm || (m != 16'd0);
      chk(fetch_req == fetched, "R2", "fetch request", fetch_req, fetched);
      if (fetched) begin
         for (int d = 0; d < $urandom_range(max_dly, 0); d++) begin
            @(negedge clk);
            chk(fetch_req && !op_valid, "R2", "fetch held", fetch_req, 1'b1);
         end
         fetch_ack = 1'b1; fetch_data = data;
         @(negedge clk);
         fetch_ack = 1'b0; fetch_data = '0;
      end
      for (int j = 0; j < 4; j++) begin
         e_elem = fetched ? data[32*j +: 32] : 32'd0;
         chk(op_valid, "R3", "op offered", op_valid, 1'b1);
         chk(op_step == 2'(j) && op_reg == {s[4:2], 2'(j)}, "R3", "step/reg",
             {op_step, op_reg}, {2'(j), s[4:2], 2'(j)});
         chk(op_elem == e_elem, fetched ? "R4" : "R2", "element", op_elem, e_elem);
         chk(op_neg == ng, "R5", "product sign", op_neg, ng);
         chk(op_we == exp_we(m, nm) && op_zero == exp_zero(m, nm, z), "R6", "lane enables",
             {op_we, op_zero}, {exp_we(m, nm), exp_zero(m, nm, z)});
         for (int d = 0; d < $urandom_range(max_dly, 0); d++) begin
            start = (d == 0);
            bcast = ~b;
            @(negedge clk);
            start = 1'b0;
            bcast = b;
            chk(op_valid && op_step == 2'(j) && op_elem == e_elem, "R8", "stall hold",
                {op_valid, op_step, op_elem}, {1'b1, 2'(j), e_elem});
            chk(busy && !done, "R11", "start while busy ignored", {busy, done}, 2'b10);
         end
         op_ready = 1'b1;
         @(negedge clk);
         op_ready = 1'b0;
         for (int d = 0; d < $urandom_range(max_dly, 0); d++) begin
            chk(!op_valid, "R7", "no issue before result", op_valid, 1'b0);
            @(negedge clk);
         end
         chk(!op_valid, "R7", "no issue before result", op_valid, 1'b0);
         fl = 5'($urandom);
         res_valid = 1'b1; res_flags = fl; res_exc = (j == fault_at);
         fl_acc = fl_acc | fl;
         @(negedge clk);
         res_valid = 1'b0; res_flags = '0; res_exc = 1'b0;
         chk(flags == fl_acc, "R10", "flags", flags, fl_acc);
         if (j == fault_at) begin
            chk(done && fault && !commit && !ud, "R9", "fault outcome",
                {done, fault, commit, ud}, 4'b1100);
            chk(fault_step == 2'(j), "R9", "fault step", fault_step, 2'(j));
            @(negedge clk);
            chk(!op_valid && !busy && !done, "R9", "stopped after fault",
                {op_valid, busy, done}, 3'b000);
            return;
         end
         if (j == 3) begin
            chk(done && commit && !fault && !ud, "R11", "commit outcome",
                {done, commit, fault, ud}, 4'b1100);
            @(negedge clk);
            chk(!done && !commit && !busy, "R11", "done pulse width", {done, commit, busy}, 3'b000);
         end else begin
            chk(!done, "R11", "no early done", done, 1'b0);
         end
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; start = 1'b0; src_idx = '0; negate = 1'b0; wmask = '0;
      nomask = 1'b0; zeroing = 1'b0; bcast = 1'b0; amode = 2'b00;
      fetch_ack = 1'b0; fetch_data = '0; op_ready = 1'b0;
      res_valid = 1'b0; res_flags = '0; res_exc = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fetch_req && !op_valid && flags == 5'd0 && fault_step == 2'd0,
          "R11", "reset state", {busy, done, fetch_req, op_valid, flags}, '0);

      // directed corners
      run_instr(5'd7,  1'b0, 16'h00ff, 1'b0, 1'b0, 1'b1, 2'b00, 4, 2); // R1 broadcast
      run_instr(5'd9,  1'b1, 16'hffff, 1'b1, 1'b0, 1'b0, 2'b11, 4, 2); // R1 register form
      run_instr(5'd13, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b10, 4, 2); // R2 no fetch, zeroing
      run_instr(5'd30, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 2'b01, 4, 3); // R2 nomask fetch
      run_instr(5'd2,  1'b0, 16'h8001, 1'b0, 1'b1, 1'b0, 2'b00, 0, 2); // R9 fault step 0
      run_instr(5'd21, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 2'b10, 2, 3); // R9 fault step 2
      run_instr(5'd31, 1'b0, 16'hffff, 1'b0, 1'b0, 1'b0, 2'b01, 3, 3); // R9 fault on last step
      run_instr(5'd4,  1'b0, 16'h0001, 1'b0, 1'b0, 1'b0, 2'b00, 4, 0); // R7 zero-delay responder

      // random mix
      for (int n = 0; n < 120; n++) begin
         logic [15:0] m;
         m = ($urandom_range(3, 0) == 0) ? 16'h0000 : 16'($urandom);
         run_instr(5'($urandom), 1'($urandom), m, ($urandom_range(3, 0) == 0),
                   1'($urandom), ($urandom_range(7, 0) == 0), 2'($urandom),
                   ($urandom_range(2, 0) == 0) ? int'($urandom_range(3, 0)) : 4, 4);
      end

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule